// File: doc/BRIEF.md
# Multi-Level Page Table Walker

The block turns a virtual address into a physical address by reading page table entries from memory, one read per table level. A request supplies a virtual address and the byte address of the root table. The walker splits the virtual address into one index field per level and a page offset. At each level it reads one entry over a single-outstanding request/response memory port and checks the entry's valid bit. A valid entry at an inner level gives the base of the next table. A valid entry at the last level gives the page frame number. The physical address is that frame number joined to the unchanged offset.

An entry whose valid bit is clear ends the walk at once with a fault. This covers two cases: an inner table that is absent in a sparse address space, and a page that is not present. The walker reports the level where the walk stopped and produces no translation. The depth is set by the `LEVELS` parameter, from one level upward. The default is two levels, with a 10-bit index per level and a 12-bit offset. Only one walk runs at a time. `busy_o` tells the requester when a new request will be taken, and each walk ends with a one-cycle `done_o` pulse.

Top module: `ptw_walker`

## Requirements
- R1: The low `OFF_W` (12) bits of `paddr_o` equal the low `OFF_W` bits of the request's virtual address. The upper bits of `paddr_o` equal `pfn_o`.
- R2: A walk that succeeds issues exactly `LEVELS` (2) memory reads. The first read uses the most significant index field (virtual address bits 31:22), and the next read uses the field below it (bits 21:12).
- R3: Each read address is the current table base plus the level's index times `ENTRY_BYTES` (4). The first base is `req_root_i`. Each later base is entry bits 31:12 followed by 12 zero bits.
- R4: An entry is valid when bit 0 is 1. When an entry with bit 0 = 0 arrives at any level, the walk ends with `fault_o` = 1 and issues no further reads. `fault_level_o` then gives that level, where 0 is the root table.
- R5: When `fault_o` is 1, both `paddr_o` and `pfn_o` read zero.
- R6: `done_o` is high for exactly one cycle at the end of every walk, whether the walk succeeds or faults.
- R7: `busy_o` is 0 when idle. It is 1 from the cycle after a request is accepted through the `done_o` cycle. A request presented while `busy_o` is 1 is ignored.
- R8: `paddr_o`, `pfn_o`, `fault_o` and `fault_level_o` change only in the cycle where `done_o` is high. At all other times they hold their last values.
- R9: After reset, `busy_o`, `done_o`, `fault_o`, `mem_req_valid_o` and `paddr_o` are all 0.
- R10: `mem_req_valid_o` is a one-cycle strobe. The next strobe comes only after the response to the previous one has arrived.
- R11: Entry bits 11:1 are ignored. A valid leaf entry with those bits set still translates using bits 31:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request; taken only while idle |
| req_vaddr_i | input | VA_W | Virtual address to translate |
| req_root_i | input | PA_W | Byte address of the root table |
| busy_o | output | 1 | A walk is in progress |
| mem_req_valid_o | output | 1 | One-cycle read strobe to memory |
| mem_req_addr_o | output | PA_W | Byte address of the entry being read |
| mem_rsp_valid_i | input | 1 | Read data is valid this cycle |
| mem_rsp_data_i | input | PA_W | Page table entry read from memory |
| done_o | output | 1 | One-cycle pulse at the end of a walk |
| fault_o | output | 1 | The last walk ended on an invalid entry |
| fault_level_o | output | LVL_W | Level at which the last fault occurred |
| pfn_o | output | PFN_W | Page frame number from the last walk |
| paddr_o | output | PA_W | Physical address from the last walk |

## Verification
Two events can fall in the same cycle: the end of one walk, shown by the `done_o` pulse, and the arrival of a new request. The bench provokes this by raising `req_valid_i` exactly in the cycle where it sees `done_o` high. It also raises a second request partway through a walk. Each stray request is judged at the ports. The read log must show no extra memory read. `busy_o` must drop after the done cycle and stay low. The held results must still belong to the walk that just finished.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_READ  = 3'd1,
        S_WAIT  = 3'd2,
        S_DONE  = 3'd3,
        S_FAULT = 3'd4
    } ptw_state_e;

endpackage

// File: rtl/ptw_index_sel.sv
module ptw_index_sel #(
    parameter int LEVELS = 2,
    parameter int IDX_W  = 10,
    parameter int LVL_W  = 1
) (
    input  logic [LEVELS*IDX_W-1:0] vpn,
    input  logic [LVL_W-1:0]        level,
    output logic [IDX_W-1:0]        idx
);

    logic [IDX_W-1:0] fld [LEVELS];

    // level 0 takes the most significant field of the page number
    for (genvar g = 0; g < LEVELS; g++) begin : g_fld
        assign fld[g] = vpn[(LEVELS-1-g)*IDX_W +: IDX_W];
    end

    always_comb begin
        idx = '0;
        for (int g = 0; g < LEVELS; g++) begin
            if (level == LVL_W'(g)) begin
                idx = fld[g];
            end
        end
    end

endmodule

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int PA_W  = 32,
    parameter int IDX_W = 10,
    parameter int EB_LG = 2
) (
    input  logic [PA_W-1:0]  base,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);

    logic [PA_W-1:0] offs;

    always_comb begin
        offs = {{(PA_W-IDX_W){1'b0}}, idx} << EB_LG;
        addr = base + offs;
    end

endmodule

// File: rtl/ptw_result.sv
module ptw_result #(
    parameter int PA_W  = 32,
    parameter int OFF_W = 12
) (
    input  logic [PA_W-OFF_W-1:0] frame,
    input  logic [OFF_W-1:0]      offset,
    output logic [PA_W-1:0]       paddr,
    output logic [PA_W-1:0]       next_base
);

    always_comb begin
        paddr     = {frame, offset};
        next_base = {frame, {OFF_W{1'b0}}};
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
#(
    parameter int LEVELS      = 2,
    parameter int IDX_W       = 10,
    parameter int OFF_W       = 12,
    parameter int PA_W        = 32,
    parameter int ENTRY_BYTES = 4,
    parameter int VA_W        = OFF_W + LEVELS*IDX_W,
    parameter int LVL_W       = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    parameter int PFN_W       = PA_W - OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid_i,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic [PA_W-1:0]  req_root_i,
    output logic             busy_o,
    output logic             mem_req_valid_o,
    output logic [PA_W-1:0]  mem_req_addr_o,
    input  logic             mem_rsp_valid_i,
    input  logic [PA_W-1:0]  mem_rsp_data_i,
    output logic             done_o,
    output logic             fault_o,
    output logic [LVL_W-1:0] fault_level_o,
    output logic [PFN_W-1:0] pfn_o,
    output logic [PA_W-1:0]  paddr_o
);

    localparam int VPN_W = LEVELS * IDX_W;
    localparam int EB_LG = $clog2(ENTRY_BYTES);
    localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

    typedef struct packed {
        ptw_state_e       state;
        logic [LVL_W-1:0] level;
        logic [PA_W-1:0]  base;
        logic [VA_W-1:0]  vaddr;
        logic             fault;
        logic [LVL_W-1:0] flevel;
        logic [PFN_W-1:0] pfn;
        logic [PA_W-1:0]  paddr;
    } walk_t;

    walk_t q, d;

    logic [IDX_W-1:0] cur_idx;
    logic [PA_W-1:0]  ent_addr;
    logic [PA_W-1:0]  leaf_paddr;
    logic [PA_W-1:0]  next_base;
    logic             ent_valid;
    logic [PFN_W-1:0] ent_frame;
    logic             unused_rsv;

    assign ent_valid  = mem_rsp_data_i[0];
    assign ent_frame  = mem_rsp_data_i[PA_W-1:OFF_W];
    assign unused_rsv = &{1'b0, mem_rsp_data_i[OFF_W-1:1]};

    ptw_index_sel #(
        .LEVELS (LEVELS),
        .IDX_W  (IDX_W),
        .LVL_W  (LVL_W)
    ) u_idx (
        .vpn   (q.vaddr[VA_W-1 -: VPN_W]),
        .level (q.level),
        .idx   (cur_idx)
    );

    ptw_entry_addr #(
        .PA_W  (PA_W),
        .IDX_W (IDX_W),
        .EB_LG (EB_LG)
    ) u_addr (
        .base (q.base),
        .idx  (cur_idx),
        .addr (ent_addr)
    );

    ptw_result #(
        .PA_W  (PA_W),
        .OFF_W (OFF_W)
    ) u_res (
        .frame     (ent_frame),
        .offset    (q.vaddr[OFF_W-1:0]),
        .paddr     (leaf_paddr),
        .next_base (next_base)
    );

    always_comb begin
        d = q;
        case (q.state)
            S_IDLE: begin
                if (req_valid_i) begin
                    d.state = S_READ;
                    d.level = '0;
                    d.base  = req_root_i;
                    d.vaddr = req_vaddr_i;
                end
            end
            S_READ: begin
                d.state = S_WAIT;
            end
            S_WAIT: begin
                if (mem_rsp_valid_i) begin
                    if (!ent_valid) begin
                        d.state  = S_FAULT;
                        d.fault  = 1'b1;
                        d.flevel = q.level;
                        d.pfn    = '0;
                        d.paddr  = '0;
                    end else if (q.level == LAST_LVL) begin
                        d.state  = S_DONE;
                        d.fault  = 1'b0;
                        d.flevel = '0;
                        d.pfn    = ent_frame;
                        d.paddr  = leaf_paddr;
                    end else begin
                        d.state = S_READ;
                        d.level = LVL_W'(q.level + 1'b1);
                        d.base  = next_base;
                    end
                end
            end
            S_DONE, S_FAULT: begin
                d.state = S_IDLE;
            end
            default: begin
                d.state = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o          = (q.state != S_IDLE);
    assign mem_req_valid_o = (q.state == S_READ);
    assign mem_req_addr_o  = ent_addr;
    assign done_o          = (q.state == S_DONE) || (q.state == S_FAULT);
    assign fault_o         = q.fault;
    assign fault_level_o   = q.flevel;
    assign pfn_o           = q.pfn;
    assign paddr_o         = q.paddr;

    // R10: a read strobe never lasts two cycles
    a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |=> !mem_req_valid_o);

    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: a fault carries no translation
    a_r5_fault_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (paddr_o == '0 && pfn_o == '0));

    // R8: results move only together with the done pulse
    a_r8_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({paddr_o, pfn_o, fault_o, fault_level_o}) |-> done_o);

    // R7: a walk starts only from a presented request
    a_r7_accept_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(req_valid_i));

    // R3: every entry read is aligned to the entry size
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> (mem_req_addr_o % ENTRY_BYTES) == 0);

endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;

    localparam logic [31:0] ROOT = 32'h0001_0000;
    localparam int NV = 7;

    localparam logic [31:0] V_VA [NV] = '{32'h0040_5ABC, 32'h007F_FFFF, 32'h0080_0000,
                                          32'h0080_800F, 32'h0080_7123, 32'h00C0_0456,
                                          32'h0000_0010};
    localparam logic [31:0] V_PA [NV] = '{32'h1234_5ABC, 32'hABCD_EFFF, 32'h0077_7000,
                                          32'h0099_900F, 32'h0, 32'h0, 32'h0};
    localparam logic V_FLT [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam logic V_LVL [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
    localparam int   V_RD  [NV] = '{2, 2, 2, 2, 2, 1, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_root = ROOT;
    logic        busy, mem_req_valid, done, fault;
    logic [31:0] mem_req_addr, paddr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic [0:0]  fault_level;
    logic [19:0] pfn;

    always #2 clk = ~clk;

    ptw_walker uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .req_valid_i     (req_valid),
        .req_vaddr_i     (req_vaddr),
        .req_root_i      (req_root),
        .busy_o          (busy),
        .mem_req_valid_o (mem_req_valid),
        .mem_req_addr_o  (mem_req_addr),
        .mem_rsp_valid_i (mem_rsp_valid),
        .mem_rsp_data_i  (mem_rsp_data),
        .done_o          (done),
        .fault_o         (fault),
        .fault_level_o   (fault_level),
        .pfn_o           (pfn),
        .paddr_o         (paddr)
    );

    // memory model: table entries, latency and read log
    logic [31:0] pt [logic [31:0]];
    int          lat = 1;
    int          cnt = 0;
    int          nreads = 0;
    logic [31:0] rsp_r = '0;
    logic [31:0] addr_log [64];

    function automatic logic [31:0] lookup(input logic [31:0] a);
        return pt.exists(a) ? pt[a] : 32'h0;
    endfunction

    always @(posedge clk) begin
        if (mem_req_valid) begin
            rsp_r <= lookup(mem_req_addr);
            cnt <= lat;
            addr_log[nreads[5:0]] <= mem_req_addr;
            nreads <= nreads + 1;
        end else if (cnt != 0) begin
            cnt <= cnt - 1;
        end
    end

    assign mem_rsp_valid = (cnt == 1);
    assign mem_rsp_data  = rsp_r;

    int total = 0;
    int bad = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic start(input logic [31:0] va);
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // watchdog: a walk that never ends counts as a failed check
    task automatic wait_done();
        int n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R6 watchdog actual=no_done expected=done");
        end
    endtask

    initial begin
        pt[32'h0001_0004] = 32'h0002_0001;
        pt[32'h0001_0008] = 32'h0003_0001;
        pt[32'h0001_000C] = 32'h0004_0000;
        pt[32'h0002_0014] = 32'h1234_5001;
        pt[32'h0002_0FFC] = 32'hABCD_E001;
        pt[32'h0003_0000] = 32'h0077_7001;
        pt[32'h0003_001C] = 32'h0088_8FFE;
        pt[32'h0003_0020] = 32'h0099_9FFF;

        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 busy", 64'(busy), 64'd0);
        chk("R9 done", 64'(done), 64'd0);
        chk("R9 fault", 64'(fault), 64'd0);
        chk("R9 memreq", 64'(mem_req_valid), 64'd0);
        chk("R9 paddr", 64'(paddr), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle after reset", 64'(busy), 64'd0);

        for (int i = 0; i < NV; i++) begin
            int s;
            logic [31:0] a0, a1;
            s = nreads;
            lat = (i % 3) + 1;
            start(V_VA[i]);
            chk("R7 busy after accept", 64'(busy), 64'd1);
            wait_done();
            chk("R4 fault flag", 64'(fault), 64'(V_FLT[i]));
            if (V_FLT[i]) begin
                chk("R4 fault level", 64'(fault_level), 64'(V_LVL[i]));
                chk("R5 paddr zero on fault", 64'(paddr), 64'd0);
            end else begin
                chk("R1 paddr", 64'(paddr), 64'(V_PA[i]));
                chk("R1 offset kept", 64'(paddr[11:0]), 64'(V_VA[i][11:0]));
                chk("R1 pfn", 64'(pfn), 64'(V_PA[i][31:12]));
            end
            if (i == 3) chk("R11 reserved bits ignored", 64'(paddr), 64'h0099_900F);
            chk("R2 R4 read count", 64'(nreads - s), 64'(V_RD[i]));
            a0 = ROOT + {20'd0, V_VA[i][31:22], 2'b00};
            chk("R3 R2 first read addr", 64'(addr_log[s[5:0]]), 64'(a0));
            if (V_RD[i] == 2) begin
                a1 = {lookup(a0)[31:12], 12'h0} + {20'd0, V_VA[i][21:12], 2'b00};
                chk("R3 R2 second read addr", 64'(addr_log[(s + 1) & 63]), 64'(a1));
            end
            @(negedge clk);
            chk("R6 done one cycle", 64'(done), 64'd0);
            chk("R7 idle after done", 64'(busy), 64'd0);
        end

        // R8: results from the last (fault) walk hold during a new walk;
        // R7: a request during the walk is ignored
        begin
            int s;
            s = nreads;
            lat = 3;
            start(V_VA[0]);
            @(negedge clk);
            chk("R8 fault held mid walk", 64'(fault), 64'd1);
            req_valid = 1'b1;
            req_vaddr = V_VA[5];
            @(negedge clk);
            req_valid = 1'b0;
            wait_done();
            chk("R7 ignored mid walk paddr", 64'(paddr), 64'(V_PA[0]));
            chk("R7 ignored mid walk reads", 64'(nreads - s), 64'd2);
            // R7: a request in the done cycle is ignored
            req_valid = 1'b1;
            req_vaddr = V_VA[2];
            @(negedge clk);
            req_valid = 1'b0;
            chk("R7 no accept in done cycle", 64'(busy), 64'd0);
            repeat (4) @(negedge clk);
            chk("R7 no read after done req", 64'(nreads - s), 64'd2);
            chk("R10 no strobe while idle", 64'(mem_req_valid), 64'd0);
            chk("R8 paddr held idle", 64'(paddr), 64'(V_PA[0]));
            chk("R8 busy stays low", 64'(busy), 64'd0);
        end

        // R10: a long latency gives one read per response
        begin
            int s;
            s = nreads;
            lat = 6;
            start(V_VA[1]);
            repeat (4) @(negedge clk);
            chk("R10 one read before response", 64'(nreads - s), 64'd1);
            wait_done();
            chk("R10 paddr slow memory", 64'(paddr), 64'(V_PA[1]));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule